// File: doc/BRIEF.md
# SPI Flash Command Engine

A register-mapped SPI master that carries out one serial-flash command at a time. Software places the command byte in an opcode register and packs a transmit count and a receive count into a count register. It then pushes the transmit bytes through a byte-wide data port that is backed by an eight-entry ring, and sets an execute bit. The engine selects the flash and sends the opcode. It then walks one ring slot per payload byte: it shifts the slot's contents out on MOSI and writes the byte received on MISO back into the same slot.

The ring is never cleared. After a transfer, each slot that was exchanged holds the flash's reply in place of the byte that was sent from it. To reach the read data, software rewinds the ring pointer, skips the transmitted positions with dummy reads, and then reads the responses. A two-bit rate field selects how the system clock is divided to make SCLK.

Top module: `flash_cmd_engine`

## Requirements
- R1: The opcode register (address 0x0) is sent first, MSB first, on every command, and it never occupies a ring slot.
- R2: The count register (address 0x1) holds the transmit count in bits [3:0] and the receive count in bits [7:4]. A field value above 8 acts as 8, and the register reads back the raw value that was written.
- R3: Each write to the data port (address 0xC) stores a byte at the ring pointer and advances the pointer. Each read with the read strobe returns the byte at the pointer and advances it. The pointer wraps modulo 8.
- R4: Address 0xD reads the ring pointer in bits [2:0] and the rate code in bits [5:4]. The rate code is written through bits [5:4] of the same address.
- R5: Writing a byte to address 0x2 with bit 4 set returns the pointer to 0 and leaves all ring contents unchanged.
- R6: Writing a byte to address 0x2 with bit 0 set starts a command. Bit 0 of address 0x2 reads 1 from the next cycle until the command ends, and 0 afterwards.
- R7: Each of the transmit-plus-receive payload slots, in order, sends the ring byte at the pointer and replaces it with the byte received. The pointer then advances, so after the command it equals (start + transmit + receive) mod 8.
- R8: SPI mode 0 is used. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. CS# stays low for exactly 16 x (1 + payload bytes) x divisor system-clock cycles, which includes half an SCLK period before the first rising edge.
- R9: Rate codes 1, 2 and 3 divide the system clock by 2, 3 and 4 per SCLK half-period. Code 0 acts as divide-by-4.
- R10: A transmit count of 0 still clocks in the full receive count, so no reply byte is lost.
- R11: An execute request made while a command runs is ignored. Writes to the opcode, count or rate registers during a command do not change that command.
- R12: After reset the pointer is 0, the engine is idle, CS# is high, SCLK is low, the rate code is 1 and every ring byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write strobe for one byte |
| reg_rd | input | 1 | Read strobe; only advances the pointer at the data port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that the bus never strobes write and read in the same cycle. They also assume that software keeps off the data port and the pointer-reset bit while bit 0 of address 0x2 reads 1. The engine gates those accesses so that it keeps ownership of the ring, but the properties about the pointer step are written for an engine that is the only user of the ring during a command. The bench polls the busy bit and touches only the opcode, count, rate and execute fields while a command runs. Its flash model changes MISO only after a rising SCLK edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int DIV_W  = 3;

  localparam logic [3:0] A_OPCODE = 4'h0;
  localparam logic [3:0] A_COUNT  = 4'h1;
  localparam logic [3:0] A_CTRL   = 4'h2;
  localparam logic [3:0] A_PORT   = 4'hC;
  localparam logic [3:0] A_STATUS = 4'hD;

  // system clocks per SCLK half-period for a rate code
  function automatic logic [DIV_W-1:0] rate_divisor(input logic [1:0] code);
    case (code)
      2'd1:    rate_divisor = DIV_W'(2);
      2'd2:    rate_divisor = DIV_W'(3);
      default: rate_divisor = DIV_W'(4);
    endcase
  endfunction

  // a byte count field saturates at the limit
  function automatic logic [CNT_W:0] limit_count(input logic [CNT_W-1:0] raw,
                                                 input int unsigned lim);
    limit_count = (int'(raw) > lim) ? (CNT_W+1)'(lim) : {1'b0, raw};
  endfunction
endpackage

// File: rtl/flash_cmd_clkdiv.sv
module flash_cmd_clkdiv
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + DIV_W'(1);
  end

  // half-period counter stays inside the selected divisor
  assert_div_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div));
endmodule

// File: rtl/flash_cmd_ring.sv
module flash_cmd_ring
  import flash_cmd_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_wr,
  input  logic [DATA_W-1:0] eng_data,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] cur,
  output logic [DATA_W-1:0] nxt
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    step = (int'(p) == DEPTH-1) ? '0 : p + PTR_W'(1);
  endfunction

  assign cur = mem[ptr];
  assign nxt = mem[step(ptr)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (eng_wr) begin
      mem[ptr] <= eng_data;
      ptr      <= step(ptr);
    end else if (push) begin
      mem[ptr] <= wdata;
      ptr      <= step(ptr);
    end else if (pop) begin
      ptr      <= step(ptr);
    end
  end

  assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0));
  assert_slot_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr && !clr) |=> (ptr == step($past(ptr))));
  assert_slot_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr && !clr) |=> (mem[$past(ptr)] == $past(eng_data)));
endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_req,
  input  logic [DATA_W-1:0] opcode,
  input  logic [CNT_W:0]    total,
  input  logic [1:0]        rate,
  input  logic              tick,
  input  logic [DATA_W-1:0] ring_cur,
  input  logic [DATA_W-1:0] ring_nxt,
  input  logic              miso,
  output logic              busy,
  output logic [DIV_W-1:0]  div,
  output logic              eng_wr,
  output logic [DATA_W-1:0] eng_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi
);
  logic [DATA_W-1:0] sh, rx;
  logic [3:0]        half;
  logic              in_op;
  logic [CNT_W:0]    left;
  logic              byte_end, finish;

  assign byte_end = busy && tick && (half == 4'd15);
  assign finish   = byte_end && (in_op ? (left == '0) : (left == (CNT_W+1)'(1)));
  assign eng_wr   = byte_end && !in_op;
  assign eng_data = rx;
  assign mosi     = busy & sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; in_op <= 1'b0;
      sh <= '0; rx <= '0; half <= '0; left <= '0; div <= DIV_W'(4);
    end else if (!busy) begin
      if (exec_req) begin
        busy  <= 1'b1;
        cs_n  <= 1'b0;
        sh    <= opcode;
        in_op <= 1'b1;
        half  <= '0;
        left  <= total;
        div   <= rate_divisor(rate);
      end
    end else if (tick) begin
      half <= half + 4'd1;
      if (!half[0]) begin
        sclk <= 1'b1;
        rx   <= {rx[DATA_W-2:0], miso};
      end else begin
        sclk <= 1'b0;
        if (finish) begin
          busy <= 1'b0;
          cs_n <= 1'b1;
        end else if (half == 4'd15) begin
          if (in_op) begin
            in_op <= 1'b0;
            sh    <= ring_cur;
          end else begin
            left  <= left - (CNT_W+1)'(1);
            sh    <= ring_nxt;
          end
        end else begin
          sh <= {sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_sclk_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_cs_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && !sclk));
  assert_sclk_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));
  assert_mosi_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk && !tick) |=> $stable(mosi));
  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exec_req && !finish) |=> (busy && $stable(div)));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  parameter int MAX_COUNT  = 8,
  localparam int PTR_W = $clog2(RING_DEPTH)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [DATA_W-1:0] op_reg, cnt_reg;
  logic [1:0]        rate_reg;
  logic              busy, tick, eng_wr;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] eng_data, ring_cur, ring_nxt;
  logic [PTR_W-1:0]  ptr;
  logic              wr_ctrl, exec_req, ptr_clr, push, pop;
  logic [CNT_W:0]    total;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign exec_req = wr_ctrl && reg_wdata[0];
  assign ptr_clr  = wr_ctrl && reg_wdata[4] && !busy;
  assign push     = reg_wr && (reg_addr == A_PORT) && !busy;
  assign pop      = reg_rd && (reg_addr == A_PORT) && !busy;
  assign total    = limit_count(cnt_reg[CNT_W-1:0], MAX_COUNT)
                  + limit_count(cnt_reg[DATA_W-1:CNT_W], MAX_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_reg <= '0; cnt_reg <= '0; rate_reg <= 2'd1;
    end else if (reg_wr) begin
      case (reg_addr)
        A_OPCODE: op_reg   <= reg_wdata;
        A_COUNT:  cnt_reg  <= reg_wdata;
        A_STATUS: rate_reg <= reg_wdata[5:4];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_OPCODE: reg_rdata = op_reg;
      A_COUNT:  reg_rdata = cnt_reg;
      A_CTRL:   reg_rdata = {7'd0, busy};
      A_PORT:   reg_rdata = ring_cur;
      A_STATUS: reg_rdata = {2'd0, rate_reg, 1'b0, 3'(ptr)};
      default:  reg_rdata = '0;
    endcase
  end

  flash_cmd_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
  );

  flash_cmd_ring #(.DEPTH(RING_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(ptr_clr), .push(push), .pop(pop),
    .wdata(reg_wdata), .eng_wr(eng_wr), .eng_data(eng_data),
    .ptr(ptr), .cur(ring_cur), .nxt(ring_nxt)
  );

  flash_cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .exec_req(exec_req), .opcode(op_reg),
    .total(total), .rate(rate_reg), .tick(tick), .ring_cur(ring_cur),
    .ring_nxt(ring_nxt), .miso(spi_miso), .busy(busy), .div(div),
    .eng_wr(eng_wr), .eng_data(eng_data), .sclk(spi_sclk),
    .cs_n(spi_cs_n), .mosi(spi_mosi)
  );

  assert_exec_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !busy) |=> busy);
  assert_ptr_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_wr) |=> $stable(ptr));
endmodule

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0, errors = 0;

  flash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  always #10 clk = ~clk;

  // flash model: reply byte k of a command is k*29 + 0x47
  function automatic logic [7:0] reply(input int k);
    reply = 8'((k * 29 + 8'h47) & 8'hFF);
  endfunction

  int         rbit = 0;
  logic [7:0] cap [0:31];
  assign spi_miso = reply(rbit / 8)[7 - (rbit % 8)];

  always @(posedge spi_sclk or negedge spi_cs_n) begin
    if (spi_sclk) begin
      if (rbit / 8 < 32) cap[rbit / 8] = {cap[rbit / 8][6:0], spi_mosi};
      rbit = rbit + 1;
    end else begin
      rbit = 0;
    end
  end

  int low_cycles = 0;
  always @(negedge clk) if (!spi_cs_n) low_cycles++;

  logic [7:0] model [8];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic pop, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = pop; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic int divisor(input int code);
    divisor = (code == 1) ? 2 : (code == 2) ? 3 : 4;
  endfunction

  function automatic int lim(input int v);
    lim = (v > 8) ? 8 : v;
  endfunction

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(4'h2, 1'b0, s);
      if (!s[0]) break;
    end
  endtask

  // one command, with optional disturbance while it runs (R11)
  task automatic run_cmd(input logic [7:0] op, input logic [7:0] cnt,
                         input int rate, input bit disturb);
    int w, r, start_low, p;
    logic [7:0] s, d, sent;
    w = lim(cnt[3:0]); r = lim(cnt[7:4]);
    wr(4'hD, 8'(rate << 4));
    wr(4'h1, cnt);
    wr(4'h0, op);
    wr(4'h2, 8'h10);
    for (int i = 0; i < w; i++) begin
      wr(4'hC, 8'h30 + 8'(i));
      model[i % 8] = 8'h30 + 8'(i);
    end
    wr(4'h2, 8'h10);
    start_low = low_cycles;
    wr(4'h2, 8'h01);
    rd(4'h2, 1'b0, s);
    check("R6 busy while running", int'(s[0]), 1);
    if (disturb) begin
      wr(4'h0, 8'hFF); wr(4'h1, 8'h88); wr(4'hD, 8'h00); wr(4'h2, 8'h01);
    end
    wait_idle();
    check("R8 R9 cs low cycles", low_cycles - start_low,
          16 * (1 + w + r) * divisor(rate));
    check("R1 opcode first", int'(cap[0]), int'(op));
    for (int j = 0; j < w + r; j++) begin
      sent = model[j % 8];
      check(j < w ? "R7 tx slot" : "R7 R10 rx slot", int'(cap[j + 1]), int'(sent));
      model[j % 8] = reply(j + 1);
    end
    rd(4'hD, 1'b0, s);
    check("R7 ptr after command", int'(s[2:0]), (w + r) % 8);
    wr(4'h2, 8'h10);
    for (int k = 0; k < 8; k++) begin
      rd(4'hC, 1'b1, d);
      check("R3 R7 ring readback", int'(d), int'(model[k]));
    end
    rd(4'hD, 1'b0, s);
    check("R3 ptr wraps", int'(s[2:0]), 0);
    p = 0;
  endtask

  // op, count, rate code
  localparam logic [23:0] VEC [6] = '{
    {8'h9F, 8'h30, 8'd1},
    {8'h03, 8'h43, 8'd2},
    {8'h02, 8'h05, 8'd3},
    {8'h0B, 8'h88, 8'd0},
    {8'h05, 8'h10, 8'd1},
    {8'hAB, 8'hFA, 8'd2}
  };

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    check("R12 cs_n idle", int'(spi_cs_n), 1);
    check("R12 sclk idle", int'(spi_sclk), 0);
    rd(4'hD, 1'b0, s);
    check("R12 R4 status", int'(s), 8'h10);
    rd(4'h2, 1'b0, s);
    check("R12 not busy", int'(s), 0);
    rd(4'hC, 1'b0, s);
    check("R12 ring zero", int'(s), 0);

    // R3 / R5: pointer steps, reset keeps contents
    wr(4'hC, 8'hAA); wr(4'hC, 8'hBB); wr(4'hC, 8'hCC);
    model[0] = 8'hAA; model[1] = 8'hBB; model[2] = 8'hCC;
    rd(4'hD, 1'b0, s);
    check("R3 ptr after pushes", int'(s[2:0]), 3);
    wr(4'h2, 8'h10);
    rd(4'hD, 1'b0, s);
    check("R5 ptr cleared", int'(s[2:0]), 0);
    rd(4'hC, 1'b1, s); check("R5 contents kept 0", int'(s), 8'hAA);
    rd(4'hC, 1'b1, s); check("R5 contents kept 1", int'(s), 8'hBB);
    rd(4'hC, 1'b1, s); check("R5 contents kept 2", int'(s), 8'hCC);
    rd(4'hD, 1'b0, s);
    check("R3 ptr after pops", int'(s[2:0]), 3);
    wr(4'h1, 8'hFA);
    rd(4'h1, 1'b0, s);
    check("R2 raw count readback", int'(s), 8'hFA);

    // table walk: R1 R2 R7 R8 R9 R10
    foreach (VEC[v])
      run_cmd(VEC[v][23:16], VEC[v][15:8], int'(VEC[v][7:0]), 1'b0);

    // R11: execute and register writes during a command
    run_cmd(8'h66, 8'h11, 1, 1'b1);
    rd(4'h0, 1'b0, s);
    check("R11 opcode reg took new value", int'(s), 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule